// File: doc/BRIEF.md
# I2C Bus Abort and Recovery Sequencer

This block brings a wedged I2C controller back into service after a transaction that failed or timed out. A single request starts a fixed sequence. The sequence strobes the sticky error flags of the attached controller clear, then waits for an outstanding STOP condition to drain, and then clears the controller's bus-busy flag. If needed, it also power-cycles the controller enable until both bus lines idle high. Each wait is bounded by a count of millisecond ticks supplied from outside.

The sequence has two stages. The soft abort always runs. The hard reset stage (enable low, wait for idle lines, enable high) is skipped only when the STOP drained in time and the error that caused recovery was a missing address acknowledge. In every other case it runs. A timed-out wait raises the failure flag, but the sequence still goes through all of its remaining steps. The sequence ends with a one-clock completion pulse that carries the failure flag.

Top module: `i2c_recovery_ctrl`

## Requirements
- R1: On a request seen in idle, `clr_berr`, `clr_stall` and `clr_nack` go high together for exactly one clock, starting the clock after the request edge.
- R2: The STOP wait ends in the first cycle in which `stop_pending` is low. If `TICK_LIMIT` (35) ticks of `ms_tick` arrive while it is still high, the wait ends on the last of those ticks. A low `stop_pending` on that same tick still counts as success.
- R3: `clr_busy` pulses for exactly one clock after the STOP wait, whatever its outcome.
- R4: When the STOP wait succeeded and the error code latched at the request equals 4'h2 (missing address acknowledge), the sequence completes without lowering `ctrl_en`. A later change of `last_err` has no effect on this choice.
- R5: Otherwise `ctrl_en` drops in the clock after `clr_busy`. It stays low until the synchronised SCL and SDA both read high, or until `TICK_LIMIT` ticks have arrived.
- R6: `ctrl_en` is high again in the same clock as `done`.
- R7: `fail` is high during `done` if either wait ran out of ticks. A timed-out STOP wait still leads to `clr_busy` and to the enable cycle.
- R8: SCL and SDA pass through two flops. With both lines released while the line wait runs, `ctrl_en` stays low for two more sampled clocks and is high, with `done`, on the third.
- R9: `done` is a one-clock pulse, and a request that arrives while a sequence runs starts no new sequence.
- R10: While reset is active and after it, the block rests with `ctrl_en` high and all strobes, `done` and `fail` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recover_req | input | 1 | Start a recovery sequence (taken in idle only) |
| last_err | input | ERR_W | Error code of the failed transaction, latched at the request |
| stop_pending | input | 1 | Controller still owes a STOP condition |
| scl_raw | input | 1 | Sampled SCL line level, asynchronous |
| sda_raw | input | 1 | Sampled SDA line level, asynchronous |
| ms_tick | input | 1 | One-clock pulse per millisecond |
| clr_berr | output | 1 | Strobe: clear bus-error flag |
| clr_stall | output | 1 | Strobe: clear clock-stall flag |
| clr_nack | output | 1 | Strobe: clear negative-acknowledge flag |
| clr_busy | output | 1 | Strobe: clear bus-busy flag |
| ctrl_en | output | 1 | Controller enable |
| done | output | 1 | Sequence finished (one clock) |
| fail | output | 1 | Valid with done: a wait timed out |

## Verification
A sequencer stuck in a wait state shows up as `ctrl_en` held low, or as a missing `clr_busy`, past the tick bound. The bench therefore counts the ticks seen in each wait against the exact limit. A wrong latched decision shows within a cycle of `clr_busy` as a `ctrl_en` drop that should not happen, or one that is missing. An extra or skipped synchroniser stage moves the rise of `ctrl_en` by one clock, and the bench samples that clock by clock. A leaked failure flag or a restarted sequence shows as a wrong `fail` at `done`, or as a second flag-clear strobe.

// File: rtl/i2crc_pkg.sv
package i2crc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLRF,
    ST_STOPW,
    ST_BUSY,
    ST_LINEW,
    ST_DONE
  } rcv_state_t;
endpackage

// File: rtl/i2crc_sync.sv
module i2crc_sync #(
  parameter int WIDTH   = 1,
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= {WIDTH{RST_VAL}};
        else        stage_q[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= {WIDTH{RST_VAL}};
        else        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/i2crc_tick_timer.sv
module i2crc_tick_timer #(
  parameter int LIMIT = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en  = clear | tick;
    cnt_d   = clear ? '0 : cnt_q + 1'b1;
    expired = tick & ~clear & (cnt_q == CW'(LIMIT - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2crc_seq.sv
module i2crc_seq
  import i2crc_pkg::*;
#(
  parameter int              ERR_W        = 4,
  parameter logic [ERR_W-1:0] NOMATCH_CODE = 4'h2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [ERR_W-1:0] last_err,
  input  logic             stop_pending,
  input  logic             lines_high,
  input  logic             tmr_expired,
  output logic             tmr_clr,
  output logic             clr_flags,
  output logic             clr_busy,
  output logic             ctrl_en,
  output logic             done,
  output logic             fail
);
  rcv_state_t state_q, state_d;
  logic nomatch_q, nomatch_d;
  logic stop_ok_q, stop_ok_d;
  logic fail_q, fail_d;

  always_comb begin
    state_d   = state_q;
    nomatch_d = nomatch_q;
    stop_ok_d = stop_ok_q;
    fail_d    = fail_q;
    case (state_q)
      ST_IDLE: if (req) begin
        state_d   = ST_CLRF;
        nomatch_d = (last_err == NOMATCH_CODE);
        stop_ok_d = 1'b0;
        fail_d    = 1'b0;
      end
      ST_CLRF: state_d = ST_STOPW;
      ST_STOPW: begin
        if (!stop_pending) begin
          stop_ok_d = 1'b1;
          state_d   = ST_BUSY;
        end else if (tmr_expired) begin
          fail_d  = 1'b1;
          state_d = ST_BUSY;
        end
      end
      ST_BUSY: state_d = (stop_ok_q && nomatch_q) ? ST_DONE : ST_LINEW;
      ST_LINEW: begin
        if (lines_high) begin
          state_d = ST_DONE;
        end else if (tmr_expired) begin
          fail_d  = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      nomatch_q <= 1'b0;
      stop_ok_q <= 1'b0;
      fail_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      nomatch_q <= nomatch_d;
      stop_ok_q <= stop_ok_d;
      fail_q    <= fail_d;
    end
  end

  always_comb begin
    clr_flags = (state_q == ST_CLRF);
    clr_busy  = (state_q == ST_BUSY);
    ctrl_en   = (state_q != ST_LINEW);
    done      = (state_q == ST_DONE);
    fail      = (state_q == ST_DONE) & fail_q;
    tmr_clr   = (state_q != ST_STOPW) & (state_q != ST_LINEW);
  end
endmodule

// File: rtl/i2c_recovery_ctrl.sv
module i2c_recovery_ctrl #(
  parameter int               TICK_LIMIT   = 35,
  parameter int               SYNC_STAGES  = 2,
  parameter int               ERR_W        = 4,
  parameter logic [ERR_W-1:0] NOMATCH_CODE = 4'h2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             recover_req,
  input  logic [ERR_W-1:0] last_err,
  input  logic             stop_pending,
  input  logic             scl_raw,
  input  logic             sda_raw,
  input  logic             ms_tick,
  output logic             clr_berr,
  output logic             clr_stall,
  output logic             clr_nack,
  output logic             clr_busy,
  output logic             ctrl_en,
  output logic             done,
  output logic             fail
);
  localparam int LINES = 2;

  logic             rst_sync_n;
  logic [LINES-1:0] lines_s;
  logic             lines_high;
  logic             tmr_clr, tmr_expired, clr_flags;

  i2crc_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  i2crc_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_line_sync (
    .clk(clk), .rst_n(rst_sync_n), .d({scl_raw, sda_raw}), .q(lines_s)
  );

  assign lines_high = &lines_s;

  i2crc_tick_timer #(.LIMIT(TICK_LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .clear(tmr_clr), .tick(ms_tick),
    .expired(tmr_expired)
  );

  i2crc_seq #(.ERR_W(ERR_W), .NOMATCH_CODE(NOMATCH_CODE)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .req(recover_req), .last_err(last_err),
    .stop_pending(stop_pending), .lines_high(lines_high),
    .tmr_expired(tmr_expired), .tmr_clr(tmr_clr), .clr_flags(clr_flags),
    .clr_busy(clr_busy), .ctrl_en(ctrl_en), .done(done), .fail(fail)
  );

  assign clr_berr  = clr_flags;
  assign clr_stall = clr_flags;
  assign clr_nack  = clr_flags;
endmodule

// File: rtl/i2crc_checker.sv
module i2crc_checker #(
  parameter int LIMIT = 35
) (
  input logic clk,
  input logic rst_n,
  input logic ms_tick,
  input logic clr_berr,
  input logic clr_busy,
  input logic ctrl_en,
  input logic done
);
  localparam int CW = $clog2(LIMIT + 2);

  logic          in_stop_q;
  logic [CW-1:0] stop_ticks_q, line_ticks_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_stop_q    <= 1'b0;
      stop_ticks_q <= '0;
      line_ticks_q <= '0;
    end else begin
      if (clr_berr)      in_stop_q <= 1'b1;
      else if (clr_busy) in_stop_q <= 1'b0;
      if (clr_berr)
        stop_ticks_q <= '0;
      else if (in_stop_q && !clr_busy && ms_tick && stop_ticks_q <= CW'(LIMIT))
        stop_ticks_q <= stop_ticks_q + 1'b1;
      if (ctrl_en)
        line_ticks_q <= '0;
      else if (ms_tick && line_ticks_q <= CW'(LIMIT))
        line_ticks_q <= line_ticks_q + 1'b1;
    end
  end

  // R2: STOP wait never outlasts its tick budget
  a_r2_stop_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ticks_q <= CW'(LIMIT));

  // R5: line wait never outlasts its tick budget
  a_r5_line_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    line_ticks_q <= CW'(LIMIT));

  // R3: the STOP wait occupies at least one clock before bus-busy is cleared
  a_r3_wait_before_busy: assert property (@(posedge clk) disable iff (!rst_n)
    clr_berr |=> (!clr_busy && !done));

  // R5: the enable only drops right after bus-busy clear
  a_r5_disable_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_en) |-> $past(clr_busy));

  // R6: the enable only returns together with completion
  a_r6_enable_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_en) |-> done);

  // R9: completion is a single-clock pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind i2c_recovery_ctrl i2crc_checker #(.LIMIT(TICK_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .clr_berr(clr_berr),
  .clr_busy(clr_busy), .ctrl_en(ctrl_en), .done(done)
);

// File: tb/test_i2c_recovery_ctrl.sv
`timescale 1ns/1ps
module test_i2c_recovery_ctrl;
  localparam int        LIMIT   = 35;
  localparam logic [3:0] NOMATCH = 4'h2;
  localparam logic [3:0] BUSERR  = 4'h7;
  localparam int        DIV     = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic recover_req = 1'b0, stop_pending = 1'b0, scl_raw = 1'b1, sda_raw = 1'b1;
  logic [3:0] last_err = 4'h0;
  logic ms_tick = 1'b0, tick_en = 1'b0;
  logic clr_berr, clr_stall, clr_nack, clr_busy, ctrl_en, done, fail;

  int n_checks = 0, n_bad = 0;
  int n_clrf = 0, n_busy = 0, stop_ticks = 0, line_ticks = 0;
  int en_low = 0, done_cyc = 0;
  bit phase_stop = 1'b0, finished = 1'b0;
  int div = 0;

  always #2.5 clk = ~clk;

  i2c_recovery_ctrl i_i2c_recovery_ctrl (
    .clk(clk), .rst_n(rst_n), .recover_req(recover_req), .last_err(last_err),
    .stop_pending(stop_pending), .scl_raw(scl_raw), .sda_raw(sda_raw),
    .ms_tick(ms_tick), .clr_berr(clr_berr), .clr_stall(clr_stall),
    .clr_nack(clr_nack), .clr_busy(clr_busy), .ctrl_en(ctrl_en),
    .done(done), .fail(fail)
  );

  always @(negedge clk) begin
    if (tick_en) begin
      div     <= (div == DIV - 1) ? 0 : div + 1;
      ms_tick <= (div == DIV - 1);
    end else begin
      div     <= 0;
      ms_tick <= 1'b0;
    end
  end

  always begin
    @(negedge clk); #1;
    if (clr_busy) begin phase_stop = 1'b0; n_busy++; end
    if (phase_stop && ms_tick) stop_ticks++;
    if (!ctrl_en) begin en_low++; if (ms_tick) line_ticks++; end
    if (done) done_cyc++;
    if (clr_berr) begin
      phase_stop = 1'b1; n_clrf++;
      stop_ticks = 0; line_ticks = 0; en_low = 0; done_cyc = 0;
    end
  end

  task automatic step();
    @(negedge clk); #2;
  endtask

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic request(input logic [3:0] err);
    last_err = err; recover_req = 1'b1;
    step();
    recover_req = 1'b0;
  endtask

  task automatic wait_done(output bit f);
    f = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (done) begin f = fail; return; end
      step();
    end
    chk(1'b0, "wait_done timeout", 0, 1);
  endtask

  task automatic t_reset();
    chk(ctrl_en == 1'b1, "R10 ctrl_en after reset", int'(ctrl_en), 1);
    chk({clr_berr, clr_stall, clr_nack, clr_busy, done, fail} == 6'b0,
        "R10 strobes idle", int'({clr_berr, clr_stall, clr_nack, clr_busy, done, fail}), 0);
  endtask

  task automatic t_soft_abort();
    bit f;
    int busy0 = n_busy;
    stop_pending = 1'b1; scl_raw = 1'b0; sda_raw = 1'b0;
    request(NOMATCH);
    chk({clr_berr, clr_stall, clr_nack} == 3'b111, "R1 flag strobes",
        int'({clr_berr, clr_stall, clr_nack}), 7);
    last_err = BUSERR;
    step();
    chk({clr_berr, clr_stall, clr_nack} == 3'b000, "R1 one clock",
        int'({clr_berr, clr_stall, clr_nack}), 0);
    tick_en = 1'b1;
    while (stop_ticks < 3) step();
    stop_pending = 1'b0;
    wait_done(f);
    tick_en = 1'b0;
    chk(f == 1'b0, "R4 no fail", int'(f), 0);
    chk(stop_ticks == 3, "R2 early stop ticks", stop_ticks, 3);
    chk(n_busy - busy0 == 1, "R3 busy clear once", n_busy - busy0, 1);
    chk(en_low == 0, "R4 no enable cycle", en_low, 0);
    step();
    scl_raw = 1'b1; sda_raw = 1'b1;
  endtask

  task automatic t_hard_reset();
    bit f;
    stop_pending = 1'b0;
    request(BUSERR);
    wait_done(f);
    chk(f == 1'b0, "R5 no fail", int'(f), 0);
    chk(en_low == 1, "R5 enable low cycles", en_low, 1);
    chk(ctrl_en == 1'b1, "R6 enable back at done", int'(ctrl_en), 1);
    step();
  endtask

  task automatic t_stop_timeout();
    bit f;
    int clrf0 = n_clrf, busy0 = n_busy;
    stop_pending = 1'b1; tick_en = 1'b1;
    request(NOMATCH);
    for (int i = 0; i < 20; i++) step();
    recover_req = 1'b1; step(); recover_req = 1'b0;
    wait_done(f);
    chk(f == 1'b1, "R7 fail on stop timeout", int'(f), 1);
    chk(stop_ticks == LIMIT, "R2 stop tick limit", stop_ticks, LIMIT);
    chk(n_busy - busy0 == 1, "R3 busy cleared after timeout", n_busy - busy0, 1);
    chk(en_low == 1, "R7 reset still runs", en_low, 1);
    for (int i = 0; i < 10; i++) step();
    chk(done_cyc == 1, "R9 done one clock", done_cyc, 1);
    chk(n_clrf - clrf0 == 1, "R9 request ignored while busy", n_clrf - clrf0, 1);
    tick_en = 1'b0; stop_pending = 1'b0;
  endtask

  task automatic t_line_timeout();
    bit f;
    stop_pending = 1'b0; sda_raw = 1'b0; tick_en = 1'b1;
    request(BUSERR);
    wait_done(f);
    chk(f == 1'b1, "R7 fail on line timeout", int'(f), 1);
    chk(line_ticks == LIMIT, "R5 line tick limit", line_ticks, LIMIT);
    chk(ctrl_en == 1'b1, "R6 enable back after timeout", int'(ctrl_en), 1);
    tick_en = 1'b0; sda_raw = 1'b1;
    step();
  endtask

  task automatic t_line_sync();
    bit f;
    stop_pending = 1'b0; scl_raw = 1'b1; sda_raw = 1'b0;
    request(BUSERR);
    for (int i = 0; i < 8; i++) step();
    chk(ctrl_en == 1'b0, "R5 enable held low", int'(ctrl_en), 0);
    sda_raw = 1'b1;
    step();
    chk(ctrl_en == 1'b0, "R8 sync stage 1", int'(ctrl_en), 0);
    step();
    chk(ctrl_en == 1'b0, "R8 sync stage 2", int'(ctrl_en), 0);
    step();
    chk(ctrl_en == 1'b1 && done == 1'b1, "R8 enable with done",
        int'({ctrl_en, done}), 3);
    wait_done(f);
    chk(f == 1'b0, "R8 no fail", int'(f), 0);
    step();
  endtask

  initial begin
    #500000;
    if (!finished) begin
      n_checks++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    t_reset();
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) step();
    t_reset();
    t_soft_abort();
    t_hard_reset();
    t_stop_timeout();
    t_line_timeout();
    t_line_sync();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
    $finish;
  end
endmodule